// File: doc/BRIEF.md
# Address-Steered SPI Bus Router

The router lets a single host SPI port reach several separately driven downstream SPI buses. The host puts a small binary destination code on a side-band address bus and raises a session enable. The router latches the code when the session opens. For the whole session it forwards the host serial clock and MOSI to the one addressed endpoint, pulls only that endpoint's active-low chip select, and returns that endpoint's MISO to the host. Every other endpoint keeps its select high, its clock at the idle level and its data line low.

A small register port lets a second master control and observe the router. Through it, that master can block chosen endpoints with a disable mask, read the latched destination and session state, and read or clear a sticky flag. The router sets this flag whenever a session opens with a code that has no endpoint behind it. All host-side signals are taken into the router clock domain, which runs much faster than the serial clock. Every output is registered.

Top module: `spi_route_hub`

## Requirements
- R1: After reset every `ep_cs_n` bit is 1, every `ep_sclk` bit is at the idle level (`SCLK_IDLE`, default 0), every `ep_mosi` bit is 0, `host_miso` is 0, and both the mask register and the error flag are 0.
- R2: When `host_men` rises with `host_addr` = a, a < `NUM_EP` and mask bit a clear, `ep_cs_n[a]` goes to 0 two clock cycles later and all other `ep_cs_n` bits stay 1.
- R3: During a session, `ep_sclk[a]` and `ep_mosi[a]` of the selected endpoint repeat `host_sclk` and `host_mosi` with two clock cycles of latency, while every other endpoint holds its clock at the idle level and its MOSI at 0.
- R4: During a granted session, `host_miso` equals `ep_miso[a]` of the selected endpoint one clock cycle later. `host_miso` is 0 whenever no endpoint is granted.
- R5: The address is captured only in the cycle where `host_men` rises. A change of `host_addr` while `host_men` stays high does not move the selection.
- R6: Two clock cycles after `host_men` falls, all `ep_cs_n` bits are 1 and all `ep_sclk` bits sit at the idle level, whatever `host_sclk` does.
- R7: Register 0 holds the disable mask, with bit i belonging to endpoint i. A set bit keeps that endpoint's select high and its clock and MOSI idle even when it is addressed. In that case `host_miso` stays 0. The mask reads back as written.
- R8: A session opened with `host_addr` >= `NUM_EP` selects no endpoint and sets a sticky error flag, which is bit 7 of register 1. The flag survives later sessions and clears only when register 1 is written with bit 7 = 1.
- R9: Register 1 reads as {bit 7 error, bit 6 session active, bits 2:0 latched address, other bits 0}. Read data appears on `reg_rdata` one clock cycle after `reg_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst | input | 1 | Synchronous active-high reset |
| host_men | input | 1 | Host session enable, active high |
| host_addr | input | ADDR_W | Destination code, latched at session start |
| host_sclk | input | 1 | Host serial clock |
| host_mosi | input | 1 | Host serial data out |
| host_miso | output | 1 | Serial data returned to host |
| ep_cs_n | output | NUM_EP | Endpoint chip selects, active low |
| ep_sclk | output | NUM_EP | Endpoint serial clocks |
| ep_mosi | output | NUM_EP | Endpoint serial data out |
| ep_miso | input | NUM_EP | Endpoint serial data in |
| reg_addr | input | 1 | Register select: 0 mask, 1 status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, registered |

## Verification
The in-RTL assertions check, on every cycle, that at most one chip select is low, that all selects return high after the session enable drops, that the latched selection stays fixed within a session, that the error flag does not drop without a clear, and that `host_miso` is quiet when no select is low. Some behaviours can only be shown by the directed scenarios. These are the exact two-cycle latency of the forwarded clock and data, the fact that the returned MISO comes from the correct endpoint, the blocking effect of the mask on an addressed endpoint, and the register readback encodings for valid and invalid codes.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;
  typedef enum logic {
    RSEL_MASK = 1'b0,
    RSEL_STAT = 1'b1
  } reg_sel_e;

  localparam int STAT_ERR_BIT = 7;
  localparam int STAT_ACT_BIT = 6;
endpackage

// File: rtl/spi_rt_session.sv
module spi_rt_session #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_men,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_sclk,
  input  logic              host_mosi,
  output logic              start_o,
  output logic              act_q,
  output logic [ADDR_W-1:0] sel_q,
  output logic              sclk_q,
  output logic              mosi_q
);
  assign start_o = host_men && !act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      sel_q  <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      act_q  <= host_men;
      sclk_q <= host_sclk;
      mosi_q <= host_mosi;
      if (start_o) sel_q <= host_addr;
    end
  end

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && host_men) |=> $stable(sel_q));
endmodule

// File: rtl/spi_rt_fanout.sv
module spi_rt_fanout #(
  parameter int   NUM_EP    = 6,
  parameter int   ADDR_W    = 3,
  parameter logic SCLK_IDLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_q,
  input  logic [ADDR_W-1:0] sel_q,
  input  logic              sclk_q,
  input  logic              mosi_q,
  input  logic [NUM_EP-1:0] mask,
  input  logic [NUM_EP-1:0] ep_miso,
  output logic [NUM_EP-1:0] ep_cs_n,
  output logic [NUM_EP-1:0] ep_sclk,
  output logic [NUM_EP-1:0] ep_mosi,
  output logic              host_miso
);
  logic [NUM_EP-1:0] grant;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign grant[i] = act_q && (sel_q == ADDR_W'(i)) && !mask[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        ep_cs_n[i] <= 1'b1;
        ep_sclk[i] <= SCLK_IDLE;
        ep_mosi[i] <= 1'b0;
      end else begin
        ep_cs_n[i] <= !grant[i];
        ep_sclk[i] <= grant[i] ? sclk_q : SCLK_IDLE;
        ep_mosi[i] <= grant[i] && mosi_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_miso <= 1'b0;
    else     host_miso <= |(grant & ep_miso);
  end

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ep_cs_n));

  // R6
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !act_q |=> (&ep_cs_n));

  // R4
  quiet_miso_chk: assert property (@(posedge clk) disable iff (rst)
    (&ep_cs_n) |-> !host_miso);
endmodule

// File: rtl/spi_rt_regs.sv
module spi_rt_regs
  import spi_rt_pkg::*;
#(
  parameter int NUM_EP = 6,
  parameter int ADDR_W = 3,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              act_q,
  input  logic [ADDR_W-1:0] sel_q,
  input  logic              reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [NUM_EP-1:0] mask,
  output logic [REG_W-1:0]  reg_rdata
);
  logic             err_q;
  logic             bad_code;
  logic             err_clr;
  logic [REG_W-1:0] stat_w;
  reg_sel_e         rsel;

  assign rsel     = reg_sel_e'(reg_addr);
  assign bad_code = start && (32'(host_addr) >= NUM_EP);
  assign err_clr  = reg_we && (rsel == RSEL_STAT) && reg_wdata[STAT_ERR_BIT];

  always_comb begin
    stat_w = '0;
    stat_w[STAT_ERR_BIT] = err_q;
    stat_w[STAT_ACT_BIT] = act_q;
    stat_w[ADDR_W-1:0]   = sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask      <= '0;
      err_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && rsel == RSEL_MASK) mask <= reg_wdata[NUM_EP-1:0];
      if (bad_code)     err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      reg_rdata <= (rsel == RSEL_MASK) ? REG_W'(mask) : stat_w;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/spi_route_hub.sv
module spi_route_hub #(
  parameter int   NUM_EP    = 6,
  parameter int   ADDR_W    = 3,
  parameter int   REG_W     = 8,
  parameter logic SCLK_IDLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_men,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_sclk,
  input  logic              host_mosi,
  output logic              host_miso,
  output logic [NUM_EP-1:0] ep_cs_n,
  output logic [NUM_EP-1:0] ep_sclk,
  output logic [NUM_EP-1:0] ep_mosi,
  input  logic [NUM_EP-1:0] ep_miso,
  input  logic              reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic              start;
  logic              act_q;
  logic [ADDR_W-1:0] sel_q;
  logic              sclk_q;
  logic              mosi_q;
  logic [NUM_EP-1:0] mask;

  spi_rt_session #(.ADDR_W(ADDR_W)) u_session (
    .clk(clk), .rst(rst), .host_men(host_men), .host_addr(host_addr),
    .host_sclk(host_sclk), .host_mosi(host_mosi), .start_o(start),
    .act_q(act_q), .sel_q(sel_q), .sclk_q(sclk_q), .mosi_q(mosi_q)
  );

  spi_rt_fanout #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .SCLK_IDLE(SCLK_IDLE)) u_fanout (
    .clk(clk), .rst(rst), .act_q(act_q), .sel_q(sel_q), .sclk_q(sclk_q),
    .mosi_q(mosi_q), .mask(mask), .ep_miso(ep_miso), .ep_cs_n(ep_cs_n),
    .ep_sclk(ep_sclk), .ep_mosi(ep_mosi), .host_miso(host_miso)
  );

  spi_rt_regs #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .start(start), .host_addr(host_addr),
    .act_q(act_q), .sel_q(sel_q), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .mask(mask), .reg_rdata(reg_rdata)
  );

  // R3
  idle_clock_chk: assert property (@(posedge clk) disable iff (rst)
    ep_cs_n[0] |-> (ep_sclk[0] == SCLK_IDLE && !ep_mosi[0]));
endmodule

// File: tb/tb_spi_route_hub.sv
module tb_spi_route_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 6;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 8;
  localparam logic [NUM_EP-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_men = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic host_sclk = 1'b0;
  logic host_mosi = 1'b0;
  logic host_miso;
  logic [NUM_EP-1:0] ep_cs_n, ep_sclk, ep_mosi;
  logic [NUM_EP-1:0] ep_miso = '0;
  logic reg_addr = 1'b0;
  logic reg_we = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_route_hub #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W), .REG_W(REG_W)) dut (
    .clk(clk), .rst(rst), .host_men(host_men), .host_addr(host_addr),
    .host_sclk(host_sclk), .host_mosi(host_mosi), .host_miso(host_miso),
    .ep_cs_n(ep_cs_n), .ep_sclk(ep_sclk), .ep_mosi(ep_mosi), .ep_miso(ep_miso),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_s(logic [ADDR_W-1:0] a);
    host_addr = a; host_men = 1'b1; wait_n(2);
  endtask

  task automatic close_s();
    host_men = 1'b0; wait_n(2);
  endtask

  task automatic reg_wr(logic a, logic [REG_W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; wait_n(1); reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic a, output logic [REG_W-1:0] d);
    reg_addr = a; wait_n(1); d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [REG_W-1:0] d;
    chk("R1 cs_n", ep_cs_n, ALL1);
    chk("R1 sclk", ep_sclk, 0);
    chk("R1 mosi", ep_mosi, 0);
    chk("R1 miso", host_miso, 0);
    reg_rd(1'b0, d); chk("R1 mask", d, 0);
    reg_rd(1'b1, d); chk("R1 err", d[7], 0);
  endtask

  task automatic t_route();
    for (int a = 0; a < NUM_EP; a++) begin
      open_s(ADDR_W'(a));
      chk("R2 select", ep_cs_n, ALL1 & ~(NUM_EP'(1) << a));
      close_s();
    end
  endtask

  task automatic t_pass();
    open_s(3'd3);
    host_sclk = 1'b1; host_mosi = 1'b1;
    wait_n(1);
    chk("R3 latency one cycle short", ep_sclk, 0);
    wait_n(1);
    chk("R3 sclk", ep_sclk, 6'b001000);
    chk("R3 mosi", ep_mosi, 6'b001000);
    host_sclk = 1'b0; host_mosi = 1'b0; wait_n(2);
    chk("R3 sclk low", ep_sclk, 0);
    close_s();
  endtask

  task automatic t_miso();
    open_s(3'd2);
    ep_miso = 6'b000100; wait_n(1);
    chk("R4 miso high", host_miso, 1);
    ep_miso = 6'b111011; wait_n(1);
    chk("R4 miso other ep", host_miso, 0);
    close_s();
    ep_miso = '1; wait_n(1);
    chk("R4 miso idle", host_miso, 0);
    ep_miso = '0;
  endtask

  task automatic t_latch();
    open_s(3'd1);
    host_addr = 3'd4; wait_n(3);
    chk("R5 latched", ep_cs_n, 6'b111101);
    close_s();
  endtask

  task automatic t_idle();
    open_s(3'd0);
    host_sclk = 1'b1; host_men = 1'b0; wait_n(2);
    chk("R6 cs released", ep_cs_n, ALL1);
    chk("R6 sclk idle", ep_sclk, 0);
    host_sclk = 1'b0; wait_n(1);
  endtask

  task automatic t_mask();
    logic [REG_W-1:0] d;
    reg_wr(1'b0, 8'h04);
    reg_rd(1'b0, d); chk("R7 mask readback", d, 8'h04);
    ep_miso = '1; host_sclk = 1'b1;
    open_s(3'd2); wait_n(1);
    chk("R7 masked cs", ep_cs_n, ALL1);
    chk("R7 masked sclk", ep_sclk, 0);
    chk("R7 masked miso", host_miso, 0);
    close_s();
    open_s(3'd3);
    chk("R7 unmasked neighbour", ep_cs_n, 6'b110111);
    close_s();
    host_sclk = 1'b0; ep_miso = '0;
    reg_wr(1'b0, 8'h00);
  endtask

  task automatic t_badaddr();
    logic [REG_W-1:0] d;
    open_s(3'd7);
    chk("R8 no select", ep_cs_n, ALL1);
    reg_rd(1'b1, d); chk("R9 status in bad session", d, 8'hC7);
    close_s();
    reg_rd(1'b1, d); chk("R9 status idle", d, 8'h87);
    open_s(3'd0);
    reg_rd(1'b1, d); chk("R8 sticky across session", d, 8'hC0);
    reg_wr(1'b1, 8'h80);
    reg_rd(1'b1, d); chk("R8 cleared", d, 8'h40);
    close_s();
    open_s(3'd6);
    reg_rd(1'b1, d); chk("R8 code 6 flagged", d[7], 1);
    close_s();
    reg_wr(1'b1, 8'h80);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_route();
    t_pass();
    t_miso();
    t_latch();
    t_idle();
    t_mask();
    t_badaddr();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule